// File: doc/BRIEF.md
# Frequent Value Dictionary Codec

This block holds a small programmable table of frequently occurring 32-bit data values and translates between full words and short 3-bit codes. A compressed victim store sits beside a direct-mapped data cache. When the cache evicts a line, the line is handed to the encoder. The encoder replaces every word with the code of its table entry, or with an escape code when the word is not in the table. When a compressed line later hits, the stored code for the requested word goes to the decoder, which rebuilds the full value in the same cycle.

The code space has eight values but only seven table slots. The all-ones code is kept as an escape that stands for "word not held". It can never be decoded, and the requester treats it as a miss. The table is filled through a load port before use. Each slot has its own valid flag, so a slot can be retired without disturbing the others. How the table contents are chosen is outside this block.

Encoding is not on the critical path. A full line of eight words is taken in one cycle and the code vector is registered, so the result appears one cycle later. Decoding is purely combinational from the code and the table registers.

Top module: `fvd_codec`

## Requirements
- R1: After reset, every table slot is invalid, `enc_done` is 0 and `enc_codes` holds all ones (every code 3'b111).
- R2: One clock edge after a load with `ld_valid`=1 to slot k (0..6), `dec_code`=k returns the loaded value with `dec_hit`=1, combinationally in the same cycle that the code is presented.
- R3: `dec_code`=3'b111 always gives `dec_hit`=0 and `dec_value`=0.
- R4: Decoding a slot whose valid flag is clear gives `dec_hit`=0 and `dec_value`=0, including a slot retired by a load with `ld_valid`=0.
- R5: Word w of a line occupies `enc_line[32w+31:32w]`, and its code occupies `enc_codes[3w+2:3w]`. A word equal to a valid slot's value is given that slot's index.
- R6: A word that equals no valid slot's value is given code 3'b111.
- R7: When several valid slots hold the same value, the encoder gives the lowest matching index.
- R8: Invalid slots never match during encoding, whatever value their storage holds (including zero after reset).
- R9: `enc_done` is 1 in exactly the cycle after a cycle with `enc_req`=1 and 0 otherwise. `enc_codes` holds its value in cycles that follow a cycle without a request.
- R10: A load addressed to index 3'b111 changes neither any slot nor any decode or encode result.
- R11: When a load and an encode request share a clock edge, the encode uses the table contents from before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Write one table slot this cycle |
| ld_idx | input | 3 | Slot index to write (3'b111 ignored) |
| ld_value | input | 32 | Value stored in the slot |
| ld_valid | input | 1 | Valid flag written with the slot (0 retires it) |
| enc_req | input | 1 | Encode the line on `enc_line` this cycle |
| enc_line | input | 256 | Eight 32-bit words, word w at bits 32w+31:32w |
| enc_done | output | 1 | Code vector on `enc_codes` was produced by the previous cycle's request |
| enc_codes | output | 24 | Eight 3-bit codes, code w at bits 3w+2:3w |
| dec_code | input | 3 | Code to expand |
| dec_value | output | 32 | Expanded value, zero when no hit |
| dec_hit | output | 1 | Code refers to a valid slot |

## Verification
The properties assume that `rst_n` is held low for at least one clock edge before any request. They also assume that the load and encode inputs are steady around each rising edge. The stability property on `enc_codes` depends on the request line being low, so the bench deliberately changes `enc_line` while idle to show that the line is not sampled then. All stimulus is applied on the falling edge and sampled away from the rising edge. Loads to the reserved index, retired slots holding live values, duplicate values and a load on the same edge as an encode are each driven on purpose rather than left to chance.

// File: rtl/fvd_pkg.sv
// Package: shared defaults for the frequent value dictionary codec.
// Assumes: one code value (all ones) is reserved as the escape.
package fvd_pkg;
    localparam int DEF_WORD_W     = 32;
    localparam int DEF_CODE_W     = 3;
    localparam int DEF_LINE_WORDS = 8;

    // Number of usable slots for a given code width (escape excluded).
    function automatic int slot_count(input int code_w);
        return (1 << code_w) - 1;
    endfunction
endpackage

// File: rtl/fvd_table.sv
// Module: fvd_table
// Holds the dictionary slots, each a value register plus a valid flag.
// Assumes: a write to the escape index addresses no slot and is dropped.
module fvd_table #(
    parameter int WORD_W = fvd_pkg::DEF_WORD_W,
    parameter int CODE_W = fvd_pkg::DEF_CODE_W,
    parameter int SLOTS  = fvd_pkg::slot_count(CODE_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [CODE_W-1:0]             wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          wr_keep,
    output logic [SLOTS-1:0][WORD_W-1:0]  slot_val,
    output logic [SLOTS-1:0]              slot_ok
);
    localparam logic [CODE_W-1:0] ESC = '1;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // Slot register: cleared by reset, rewritten when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_val[s] <= '0;
                slot_ok[s]  <= 1'b0;
            end else if (wr_en && wr_idx == CODE_W'(s)) begin
                slot_val[s] <= wr_data;
                slot_ok[s]  <= wr_keep;
            end
        end
    end

    // A write aimed at the escape index must leave the whole table untouched.
    assert_reserved_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == ESC) |=> ($stable(slot_ok) && $stable(slot_val)));
endmodule

// File: rtl/fvd_match.sv
// Module: fvd_match
// Maps one word to the lowest valid slot index holding it, else the escape.
// Assumes: purely combinational; registered by the parent.
module fvd_match #(
    parameter int WORD_W = fvd_pkg::DEF_WORD_W,
    parameter int CODE_W = fvd_pkg::DEF_CODE_W,
    parameter int SLOTS  = fvd_pkg::slot_count(CODE_W)
) (
    input  logic [WORD_W-1:0]             word,
    input  logic [SLOTS-1:0][WORD_W-1:0]  slot_val,
    input  logic [SLOTS-1:0]              slot_ok,
    output logic [CODE_W-1:0]             code
);
    // Priority scan: walk from the top slot down so the lowest match wins.
    always_comb begin
        code = '1;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_ok[s] && slot_val[s] == word) begin
                code = CODE_W'(s);
            end
        end
    end
endmodule

// File: rtl/fvd_lookup.sv
// Module: fvd_lookup
// Expands a code to its slot value in the same cycle.
// Assumes: the escape code matches no slot index, so it never hits.
module fvd_lookup #(
    parameter int WORD_W = fvd_pkg::DEF_WORD_W,
    parameter int CODE_W = fvd_pkg::DEF_CODE_W,
    parameter int SLOTS  = fvd_pkg::slot_count(CODE_W)
) (
    input  logic [CODE_W-1:0]             code,
    input  logic [SLOTS-1:0][WORD_W-1:0]  slot_val,
    input  logic [SLOTS-1:0]              slot_ok,
    output logic [WORD_W-1:0]             value,
    output logic                          hit
);
    // Select the addressed slot; invalid or escape yields zero and no hit.
    always_comb begin
        value = '0;
        hit   = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (code == CODE_W'(s) && slot_ok[s]) begin
                value = slot_val[s];
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fvd_codec.sv
// Module: fvd_codec (top)
// Frequent value dictionary: line encoder with one-cycle latency and
// a combinational single-code decoder sharing one slot table.
// Assumes: synchronous active-low reset asserted before first use.
module fvd_codec #(
    parameter int WORD_W     = fvd_pkg::DEF_WORD_W,
    parameter int CODE_W     = fvd_pkg::DEF_CODE_W,
    parameter int LINE_WORDS = fvd_pkg::DEF_LINE_WORDS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en,
    input  logic [CODE_W-1:0]              ld_idx,
    input  logic [WORD_W-1:0]              ld_value,
    input  logic                           ld_valid,
    input  logic                           enc_req,
    input  logic [WORD_W*LINE_WORDS-1:0]   enc_line,
    output logic                           enc_done,
    output logic [CODE_W*LINE_WORDS-1:0]   enc_codes,
    input  logic [CODE_W-1:0]              dec_code,
    output logic [WORD_W-1:0]              dec_value,
    output logic                           dec_hit
);
    localparam int                SLOTS = fvd_pkg::slot_count(CODE_W);
    localparam int                CVEC_W = CODE_W * LINE_WORDS;
    localparam logic [CODE_W-1:0] ESC   = '1;

    logic [SLOTS-1:0][WORD_W-1:0] slot_val;
    logic [SLOTS-1:0]             slot_ok;
    logic [CVEC_W-1:0]            codes_next;

    fvd_table #(.WORD_W(WORD_W), .CODE_W(CODE_W), .SLOTS(SLOTS)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_en),
        .wr_idx   (ld_idx),
        .wr_data  (ld_value),
        .wr_keep  (ld_valid),
        .slot_val (slot_val),
        .slot_ok  (slot_ok)
    );

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        fvd_match #(.WORD_W(WORD_W), .CODE_W(CODE_W), .SLOTS(SLOTS)) i_match (
            .word     (enc_line[w*WORD_W +: WORD_W]),
            .slot_val (slot_val),
            .slot_ok  (slot_ok),
            .code     (codes_next[w*CODE_W +: CODE_W])
        );
    end

    // Output register for the code vector and its completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_done  <= 1'b0;
            enc_codes <= '1;
        end else begin
            enc_done <= enc_req;
            if (enc_req) begin
                enc_codes <= codes_next;
            end
        end
    end

    fvd_lookup #(.WORD_W(WORD_W), .CODE_W(CODE_W), .SLOTS(SLOTS)) i_lookup (
        .code     (dec_code),
        .slot_val (slot_val),
        .slot_ok  (slot_ok),
        .value    (dec_value),
        .hit      (dec_hit)
    );

    // Completion follows a request by exactly one cycle.
    assert_done_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enc_req |=> enc_done);
    assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_req |=> !enc_done);
    // Codes hold while no request is made.
    assert_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_req |=> $stable(enc_codes));
    // The escape code is never expanded.
    assert_escape_never_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_code == ESC) |-> (!dec_hit && dec_value == '0));
endmodule

// File: tb/test_fvd_codec.sv
module test_fvd_codec;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_en = 1'b0;
    logic [2:0]   ld_idx = '0;
    logic [31:0]  ld_value = '0;
    logic         ld_valid = 1'b0;
    logic         enc_req = 1'b0;
    logic [255:0] enc_line = '0;
    logic         enc_done;
    logic [23:0]  enc_codes;
    logic [2:0]   dec_code = '0;
    logic [31:0]  dec_value;
    logic         dec_hit;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_val [7];
    logic        m_ok  [7];

    logic [23:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    fvd_codec i_fvd_codec (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_value(ld_value), .ld_valid(ld_valid),
        .enc_req(enc_req), .enc_line(enc_line),
        .enc_done(enc_done), .enc_codes(enc_codes),
        .dec_code(dec_code), .dec_value(dec_value), .dec_hit(dec_hit)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_codes(input logic [255:0] line);
        logic [23:0] r;
        for (int w = 0; w < 8; w++) begin
            logic [2:0] c;
            c = 3'b111;
            for (int s = 6; s >= 0; s--)
                if (m_ok[s] && m_val[s] == line[w*32 +: 32]) c = 3'(s);
            r[w*3 +: 3] = c;
        end
        return r;
    endfunction

    // Monitor: pops expected code vectors as the design completes requests.
    always @(negedge clk) begin
        if (rst_n && enc_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", 64'(enc_codes), 64'h0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(enc_codes == e, t, 64'(enc_codes), 64'(e));
            end
        end
    end

    task automatic load(input int idx, input logic [31:0] v, input bit keep);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'(idx); ld_value = v; ld_valid = keep;
        if (idx < 7) begin m_val[idx] = v; m_ok[idx] = keep; end
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    // Driver: issues one request (optionally with a load on the same edge).
    task automatic enc_cycle(input logic [255:0] line, input string tag,
                             input bit with_ld, input int idx, input logic [31:0] v);
        @(negedge clk);
        enc_req = 1'b1; enc_line = line;
        exp_q.push_back(model_codes(line));
        tag_q.push_back(tag);
        ld_en = with_ld; ld_idx = 3'(idx); ld_value = v; ld_valid = 1'b1;
        if (with_ld && idx < 7) begin m_val[idx] = v; m_ok[idx] = 1'b1; end
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        enc_req = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic dec_check(input int c, input string tag);
        logic [31:0] ev;
        logic        eh;
        @(negedge clk);
        dec_code = 3'(c);
        #1;
        eh = (c < 7) ? m_ok[c] : 1'b0;
        ev = eh ? m_val[c] : 32'h0;
        check(dec_hit == eh && dec_value == ev, tag, {31'h0, dec_hit, dec_value}, {31'h0, eh, ev});
    endtask

    function automatic logic [255:0] mk_line(input logic [31:0] a, b, c, d, e, f, g, h);
        return {h, g, f, e, d, c, b, a};
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] pool [10];
        logic [23:0] held;
        for (int s = 0; s < 7; s++) begin m_val[s] = '0; m_ok[s] = 1'b0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, still in reset
        check(enc_done == 1'b0, "R1 done at reset", 64'(enc_done), 64'h0);
        check(enc_codes == 24'hFFFFFF, "R1 codes at reset", 64'(enc_codes), 64'hFFFFFF);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) dec_check(c, "R1 decode after reset");

        // R8: zero word must not match reset slots
        enc_cycle('0, "R8 zero line vs empty table", 1'b0, 0, 0);
        idle(2);

        // R2: fill table, slot 6 duplicates slot 2
        load(0, 32'h0000_0000, 1'b1);
        load(1, 32'hFFFF_FFFF, 1'b1);
        load(2, 32'h0000_0001, 1'b1);
        load(3, 32'hDEAD_BEEF, 1'b1);
        load(4, 32'h0000_0004, 1'b1);
        load(5, 32'h1234_5678, 1'b1);
        load(6, 32'h0000_0001, 1'b1);
        for (int c = 0; c < 7; c++) dec_check(c, "R2 decode loaded slot");
        dec_check(7, "R3 escape decode");

        // R5 R6 R7: mixed line
        enc_cycle(mk_line(32'h0, 32'h1, 32'hDEAD_BEEF, 32'h5555_AAAA,
                          32'hFFFF_FFFF, 32'h4, 32'h1234_5678, 32'h7),
                  "R5 R6 R7 mixed line", 1'b0, 0, 0);
        idle(1);
        check(model_codes(mk_line(32'h1,32'h1,32'h1,32'h1,32'h1,32'h1,32'h1,32'h1)) == {8{3'd2}},
              "R7 model sanity", 64'h0, 64'h0);

        // R10: load to reserved index is ignored
        load(7, 32'hCAFE_F00D, 1'b1);
        for (int c = 0; c < 8; c++) dec_check(c, "R10 table after reserved load");
        enc_cycle(mk_line(32'hCAFE_F00D, 32'hCAFE_F00D, 32'h0, 32'h1,
                          32'hCAFE_F00D, 32'h4, 32'h9, 32'hCAFE_F00D),
                  "R10 reserved value not encoded", 1'b0, 0, 0);
        idle(1);

        // R4 R8: retire slot 2, value 1 now falls to slot 6
        load(2, 32'h0000_0001, 1'b0);
        dec_check(2, "R4 retired slot decode");
        enc_cycle(mk_line(32'h1, 32'h1, 32'h0, 32'h0, 32'h1, 32'h1, 32'h2, 32'h1),
                  "R8 retired slot skipped", 1'b0, 0, 0);
        idle(1);

        // R11: load on same edge as request uses old contents
        enc_cycle(mk_line(32'hABCD_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hABCD_0000),
                  "R11 encode beside load", 1'b1, 4, 32'hABCD_0000);
        enc_cycle(mk_line(32'hABCD_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hABCD_0000),
                  "R11 encode after load", 1'b0, 0, 0);
        idle(1);
        dec_check(4, "R2 reloaded slot");

        // R9: codes hold while idle even as the line changes
        @(negedge clk);
        held = enc_codes;
        enc_line = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(enc_done == 1'b0, "R9 done low when idle", 64'(enc_done), 64'h0);
        check(enc_codes == held, "R9 codes held", 64'(enc_codes), 64'(held));

        // R5 R6: back-to-back pseudo-random lines
        pool = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h4, 32'h1234_5678,
                 32'hABCD_0000, 32'h77, 32'h8000_0000, 32'hCAFE_F00D};
        for (int n = 0; n < 24; n++) begin
            logic [255:0] ln;
            for (int w = 0; w < 8; w++) ln[w*32 +: 32] = pool[$urandom_range(9)];
            enc_cycle(ln, "R5 R6 R9 streamed line", 1'b0, 0, 0);
        end
        idle(3);

        check(exp_q.size() == 0, "R9 all requests completed", 64'(exp_q.size()), 64'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule